// File: doc/BRIEF.md
# Partitionable Packed SIMD ALU

This block is a single-stage integer ALU that handles each 64-bit operand as a short vector of packed subwords. A two-bit lane mode picks the subword width at run time: 8, 16, 32 or 64 bits. Every mode uses the same byte-sliced adder. The carry between two adjacent bytes is cut wherever a lane begins, so lanes of any width come from one datapath and no extra register ports are needed.

The opcode selects one of five operations. Plain add and subtract wrap inside each lane. Saturating add and subtract clamp each lane to signed or unsigned limits, and the signedness flag picks which pair of limits applies. Sum of absolute differences always works on unsigned bytes and reduces the eight byte differences to one scalar. The result is computed combinationally from the inputs and captured in one output register, so the block takes one operation per cycle and returns each result one cycle later.

Top module: `simd_alu`

## Requirements
- R1: While rst_ni is low, result_o is zero. After reset, the result for the inputs present at a rising clock edge appears on result_o after that edge and holds until the next edge.
- R2: lane_mode_i selects the lane width: 00 for 8-bit, 01 for 16-bit, 10 for 32-bit, 11 for 64-bit. Lane n occupies bits [n*w +: w]. Opcode 000 (add) gives a sum per lane that wraps modulo 2^w, and no carry passes into the next lane.
- R3: Opcode 001 (subtract) gives op_a minus op_b per lane, wrapping modulo 2^w, and no borrow passes into the next lane.
- R4: Opcode 010 (saturating add) with signed_i=0 and 8-, 16- or 32-bit lanes clamps any lane sum above 2^w-1 to 2^w-1.
- R5: Opcode 011 (saturating subtract) with signed_i=0 and 8-, 16- or 32-bit lanes clamps any negative lane difference to 0.
- R6: Opcodes 010 and 011 with signed_i=1 and 8-, 16- or 32-bit lanes treat the lanes as two's complement. Results above 2^(w-1)-1 clamp to that value, and results below -2^(w-1) clamp to -2^(w-1).
- R7: Opcodes 010 and 011 with lane mode 11 give the wrapping 64-bit sum or difference.
- R8: Opcode 100 (sum of absolute differences) adds |a_k - b_k| over the eight unsigned bytes k. The sum is zero-extended into result_o, and lane_mode_i and signed_i have no effect on it.
- R9: Opcodes 101, 110 and 111 give a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 64 | First packed operand |
| op_b_i | input | 64 | Second packed operand |
| opcode_i | input | 3 | Operation select |
| lane_mode_i | input | 2 | Lane width select |
| signed_i | input | 1 | Signed (1) or unsigned (0) clamp limits |
| result_o | output | 64 | Registered result word |

## Verification
The hardest case to reach is a carry or borrow that ripples through every byte of a lane right up to the lane boundary. Random operands seldom do this in 32- or 64-bit lanes. Directed words of all ones plus one, and zero minus one, are applied in every lane mode to produce it. Saturation at both limits is forced with operands one step past each signed and unsigned limit. A long random run, compared on every clock against a lane-by-lane integer model, then covers the mixed cases.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [1:0] {
    LANE_8  = 2'b00,
    LANE_16 = 2'b01,
    LANE_32 = 2'b10,
    LANE_64 = 2'b11
  } lane_mode_e;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDS = 3'd2,
    OP_SUBS = 3'd3,
    OP_SAD  = 3'd4
  } alu_op_e;
endpackage

// File: rtl/simd_lane_adder.sv
module simd_lane_adder #(
  parameter int NB = 8
) (
  input  logic [NB*8-1:0] a_i,
  input  logic [NB*8-1:0] b_i,
  input  logic            sub_i,
  input  logic [NB-1:0]   lane_start_i,
  output logic [NB*8-1:0] sum_o,
  output logic [NB-1:0]   b_msb_o,
  output logic [NB-1:0]   cout_o
);
  logic [NB*8-1:0] b_eff;
  logic [NB-1:0]   co;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign cout_o = co;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic cin;
    if (k == 0) begin : g_first
      assign cin = sub_i;
    end else begin : g_chain
      // cut the chain at a lane start: inject the add/sub carry instead
      assign cin = lane_start_i[k] ? sub_i : co[k-1];
    end
    assign {co[k], sum_o[8*k +: 8]} = {1'b0, a_i[8*k +: 8]} + {1'b0, b_eff[8*k +: 8]} + {8'd0, cin};
    assign b_msb_o[k] = b_eff[8*k+7];
  end
endmodule

// File: rtl/simd_saturate.sv
module simd_saturate #(
  parameter int NB    = 8,
  parameter int IDX_W = $clog2(NB)
) (
  input  logic [NB*8-1:0]  sum_i,
  input  logic [NB-1:0]    a_msb_i,
  input  logic [NB-1:0]    b_msb_i,
  input  logic [NB-1:0]    cout_i,
  input  logic [IDX_W-1:0] lane_msk_i,
  input  logic             sat_en_i,
  input  logic             signed_i,
  input  logic             sub_i,
  output logic [NB*8-1:0]  res_o
);
  logic [NB-1:0] hit;
  logic [NB-1:0] up;

  // flags are meaningful only at the top byte of each lane
  always_comb begin
    for (int k = 0; k < NB; k++) begin
      logic s_msb, ovf_s;
      s_msb = sum_i[8*k+7];
      ovf_s = (a_msb_i[k] == b_msb_i[k]) && (s_msb != a_msb_i[k]);
      hit[k] = signed_i ? ovf_s : (sub_i ? ~cout_i[k] : cout_i[k]);
      up[k]  = signed_i ? ~a_msb_i[k] : ~sub_i;
    end
  end

  always_comb begin
    for (int k = 0; k < NB; k++) begin
      logic [IDX_W-1:0] idx, top;
      logic             is_top;
      idx    = IDX_W'(k);
      top    = idx | lane_msk_i;
      is_top = (top == idx);
      if (sat_en_i && hit[top]) begin
        if (signed_i && is_top) res_o[8*k +: 8] = up[top] ? 8'h7f : 8'h80;
        else                    res_o[8*k +: 8] = up[top] ? 8'hff : 8'h00;
      end else begin
        res_o[8*k +: 8] = sum_i[8*k +: 8];
      end
    end
  end
endmodule

// File: rtl/simd_sad.sv
module simd_sad #(
  parameter int NB    = 8,
  parameter int SAD_W = $clog2(NB*255+1)
) (
  input  logic [NB*8-1:0]  a_i,
  input  logic [NB*8-1:0]  b_i,
  output logic [SAD_W-1:0] sad_o
);
  always_comb begin
    logic [SAD_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < NB; k++) begin
      logic [7:0] x, y, d;
      x = a_i[8*k +: 8];
      y = b_i[8*k +: 8];
      d = (x > y) ? (x - y) : (y - x);
      acc = acc + SAD_W'(d);
    end
    sad_o = acc;
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [2:0]        opcode_i,
  input  logic [1:0]        lane_mode_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int NB    = DATA_W / 8;
  localparam int IDX_W = $clog2(NB);
  localparam int SAD_W = $clog2(NB*255+1);

  alu_op_e          op;
  lane_mode_e       mode;
  logic [IDX_W-1:0] lane_msk;
  logic [NB-1:0]    lane_start, a_msb, b_msb, cout;
  logic [DATA_W-1:0] sum, sat_res, res_d;
  logic [SAD_W-1:0] sad;
  logic             is_sub, sat_en;

  assign op   = alu_op_e'(opcode_i);
  assign mode = lane_mode_e'(lane_mode_i);

  always_comb begin
    unique case (mode)
      LANE_8:  lane_msk = IDX_W'(0);
      LANE_16: lane_msk = IDX_W'(1);
      LANE_32: lane_msk = IDX_W'(3);
      default: lane_msk = '1;
    endcase
  end

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign lane_start[k] = (IDX_W'(k) & lane_msk) == '0;
    assign a_msb[k]      = op_a_i[8*k+7];
  end

  assign is_sub = (op == OP_SUB) || (op == OP_SUBS);
  assign sat_en = ((op == OP_ADDS) || (op == OP_SUBS)) && (mode != LANE_64);

  simd_lane_adder #(.NB(NB)) u_adder (
    .a_i          (op_a_i),
    .b_i          (op_b_i),
    .sub_i        (is_sub),
    .lane_start_i (lane_start),
    .sum_o        (sum),
    .b_msb_o      (b_msb),
    .cout_o       (cout)
  );

  simd_saturate #(.NB(NB), .IDX_W(IDX_W)) u_sat (
    .sum_i      (sum),
    .a_msb_i    (a_msb),
    .b_msb_i    (b_msb),
    .cout_i     (cout),
    .lane_msk_i (lane_msk),
    .sat_en_i   (sat_en),
    .signed_i   (signed_i),
    .sub_i      (is_sub),
    .res_o      (sat_res)
  );

  simd_sad #(.NB(NB), .SAD_W(SAD_W)) u_sad (
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .sad_o (sad)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_ADDS, OP_SUBS: res_d = sat_res;
      OP_SAD:                           res_d = DATA_W'(sad);
      default:                          res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) result_o <= '0;
    else         result_o <= res_d;
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic [2:0]        opcode_i,
  input logic [1:0]        lane_mode_i,
  input logic              signed_i,
  input logic [DATA_W-1:0] result_o
);
  localparam int NB    = DATA_W / 8;
  localparam int SAD_W = $clog2(NB*255+1);
  localparam logic [DATA_W-1:0] B80 = {NB{8'h80}};
  localparam logic [DATA_W-1:0] B7F = {NB{8'h7f}};

  AST_ADD_ZERO_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == 3'd0 && op_b_i == '0) |=> result_o == $past(op_a_i)); // R2
  AST_SUB_SELF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == 3'd1 && op_a_i == op_b_i) |=> result_o == '0); // R3
  AST_USAT_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == 3'd2 && !signed_i && lane_mode_i != 2'b11 && op_a_i == '1) |=> result_o == '1); // R4
  AST_USAT_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == 3'd3 && !signed_i && lane_mode_i != 2'b11 && op_a_i == '0) |=> result_o == '0); // R5
  AST_SSAT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == 3'd3 && signed_i && lane_mode_i == 2'b00 && op_a_i == '0 && op_b_i == B80) |=> result_o == B7F); // R6
  AST_WIDE_SAT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == 3'd2 && lane_mode_i == 2'b11) |=> result_o == $past(op_a_i + op_b_i)); // R7
  AST_SAD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == 3'd4) |=> result_o[DATA_W-1:SAD_W] == '0); // R8
  AST_SPARE_OP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i > 3'd4) |=> result_o == '0); // R9
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_a_i      (op_a_i),
  .op_b_i      (op_b_i),
  .opcode_i    (opcode_i),
  .lane_mode_i (lane_mode_i),
  .signed_i    (signed_i),
  .result_o    (result_o)
);

// File: tb/simd_alu_bench.sv
module simd_alu_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [63:0] op_a_i = '0, op_b_i = '0;
  logic [2:0]  opcode_i = '0;
  logic [1:0]  lane_mode_i = '0;
  logic        signed_i = 1'b0;
  logic [63:0] result_o;

  int n_run = 0, n_fail = 0;
  logic [63:0] exp_q;
  string       tag_q;
  bit          pend = 1'b0;

  always #5 clk_i = ~clk_i;

  simd_alu u_simd_alu (.*);

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic [2:0] op,
                                        logic [1:0] md, logic sg);
    logic [63:0] r = '0;
    int w = 8 << md;
    if (op == 3'd4) begin
      int s = 0;
      for (int k = 0; k < 8; k++) begin
        int x = int'(a[8*k +: 8]);
        int y = int'(b[8*k +: 8]);
        s += (x > y) ? x - y : y - x;
      end
      return 64'(s);
    end
    if (op > 3'd4) return '0;
    for (int l = 0; l < 64 / w; l++) begin
      logic [63:0] msk, la, lb;
      logic signed [65:0] xa, xb, rr, hi, lo;
      msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      la = (a >> (l*w)) & msk;
      lb = (b >> (l*w)) & msk;
      xa = $signed({2'b00, la});
      xb = $signed({2'b00, lb});
      if (sg && la[w-1]) xa = xa - (66'sd1 <<< w);
      if (sg && lb[w-1]) xb = xb - (66'sd1 <<< w);
      rr = (op[0]) ? xa - xb : xa + xb;
      if (op[1] && w < 64) begin
        hi = sg ? (66'sd1 <<< (w-1)) - 66'sd1 : (66'sd1 <<< w) - 66'sd1;
        lo = sg ? -(66'sd1 <<< (w-1)) : 66'sd0;
        if (rr > hi) rr = hi;
        if (rr < lo) rr = lo;
      end
      r = r | ((rr[63:0] & msk) << (l*w));
    end
    return r;
  endfunction

  function automatic string tag_of(logic [2:0] op, logic [1:0] md, logic sg);
    if (op == 3'd0) return "R2";
    if (op == 3'd1) return "R3";
    if (op == 3'd4) return "R8";
    if (op > 3'd4)  return "R9";
    if (md == 2'b11) return "R7";
    if (sg) return "R6";
    return (op == 3'd2) ? "R4" : "R5";
  endfunction

  task automatic check(logic [63:0] exp, string tag);
    n_run++;
    if (result_o !== exp) begin
      n_fail++;
      $display("FAIL %s: result_o=%h expected=%h", tag, result_o, exp);
    end
  endtask

  // one operation per negedge; previous one checked first (R1 one-cycle latency)
  task automatic apply(logic [63:0] a, logic [63:0] b, logic [2:0] op, logic [1:0] md, logic sg);
    @(negedge clk_i);
    if (pend) check(exp_q, tag_q);
    op_a_i = a; op_b_i = b; opcode_i = op; lane_mode_i = md; signed_i = sg;
    exp_q = model(a, b, op, md, sg);
    tag_q = tag_of(op, md, sg);
    pend = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    op_a_i = '1; op_b_i = '1; opcode_i = 3'd0;
    repeat (3) begin
      @(negedge clk_i);
      check('0, "R1");  // reset holds output at zero
    end
    rst_ni = 1'b1;
    // R2 / R3: full-lane carry and borrow ripple to each boundary
    for (int m = 0; m < 4; m++) begin
      apply('1, 64'h0101_0101_0101_0101, 3'd0, 2'(m), 1'b0);
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1 << 0, 3'd0, 2'(m), 1'b0);
      apply('0, 64'h0000_0001_0001_0101, 3'd1, 2'(m), 1'b0);
      apply(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 3'd1, 2'(m), 1'b1);
    end
    // R4 / R5 / R6 / R7: both clamp limits, both signedness, every mode
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        apply(64'hF0F0_F0F0_F0F0_F0F0, 64'h2020_2020_2020_2020, 3'd2, 2'(m), 1'(s));
        apply(64'h7F7F_7F7F_7FFF_7FFF, 64'h0101_0101_0001_0001, 3'd2, 2'(m), 1'(s));
        apply(64'h8080_8080_8000_8000, 64'h0101_0101_0001_0001, 3'd3, 2'(m), 1'(s));
        apply(64'h0010_0010_0010_0010, 64'h0020_0005_0020_0005, 3'd3, 2'(m), 1'(s));
        apply('0, 64'h8080_8080_8080_8080, 3'd3, 2'(m), 1'(s));
      end
    end
    // R8: extremes and mode/sign independence
    apply('1, '0, 3'd4, 2'b00, 1'b0);
    apply('0, '1, 3'd4, 2'b11, 1'b1);
    apply(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 3'd4, 2'b01, 1'b0);
    apply(64'h0010_FF00_8001_7F80, 64'h2000_00FF_0180_807F, 3'd4, 2'b10, 1'b1);
    // R9: unused opcodes
    for (int o = 5; o < 8; o++) apply('1, '1, 3'(o), 2'b00, 1'b0);
    // mixed random traffic
    for (int i = 0; i < 3000; i++)
      apply({$urandom, $urandom}, {$urandom, $urandom}, 3'($urandom_range(0, 7)),
            2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    @(negedge clk_i);
    check(exp_q, tag_q);
    @(negedge clk_i);
    check(exp_q, "R1");  // output holds with unchanged inputs
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule